// File: doc/BRIEF.md
# Eager Release Restore Controller

When a branch mispredict or exception squashes a stretch of the leading thread's reorder buffer, some squashed instructions may have let an older physical register go early, because its value was still held by the redundant thread. This controller puts those values back. It receives the squashed index range, visits every entry in it from youngest to oldest, one entry per cycle, and for each entry whose early-release flag is set it fetches the old value. The value comes from the register value queue slot if the trailing thread has not yet committed the writer instruction. Otherwise it comes from the trailer's checked register file. The value is written into the leading register file under the original physical register, and that register is taken back out of the free pool.

The controller has four states. IDLE waits for a squash. A squash in IDLE or DONE enters WALK, which samples the range and the ROB head used for age ordering. WALK processes the entry under the cursor each cycle. It moves to DRAIN when the cursor reaches the oldest bound and the extra latency is non-zero, and straight to DONE otherwise. DRAIN waits EXTRA_LAT cycles, which models an extra recovery penalty, and then moves to DONE. A squash arriving in WALK or DRAIN merges into the range and leads to WALK. DONE lasts one cycle, pulses resume, and returns to IDLE.

Top module: `eager_restore_ctrl`

## Requirements
- R1: A squash (sq_valid high at a clock edge, with inclusive ROB indices sq_oldest..sq_youngest taken circularly, ages counted from rob_head) starts a walk in the next cycle. rob_rd_idx shows one entry per cycle, from sq_youngest down to sq_oldest.
- R2: Only a visited entry with rob_rel=1 produces a write. In that cycle lrf_we=1 and lrf_waddr=rob_preg. An entry with rob_rel=0 produces no write.
- R3: If the trailer has not yet committed the writer, the write data is vq_rdata and vq_raddr=rob_vq_slot. This case holds when the INUM_W-bit difference trl_done_inum-rob_inum has its top bit set, which makes the comparison wrap-safe.
- R4: Otherwise the write data is trl_rdata, read at trl_raddr=rob_lreg. This includes the case where the two numbers are equal.
- R5: Every write comes with realloc_valid=1 and realloc_preg equal to the written register. realloc_valid is low in every other cycle.
- R6: busy is high from the cycle after the squash, through the walk and then EXTRA_LAT further cycles, and is low otherwise.
- R7: resume is a single-cycle pulse in the cycle after the last busy cycle, and it is never high together with busy.
- R8: When several squashed entries restore the same physical register, the register ends up holding the value restored by the oldest of them.
- R9: A squash while busy is merged, not dropped. The walk restarts from the younger of the new youngest index and the entry just visited (from the new youngest when the squash arrives in DRAIN). The oldest bound becomes the older of the two oldest bounds, and no resume is given before the merged walk ends.
- R10: A squash in the resume cycle starts a new walk, with rob_head sampled afresh.
- R11: During reset busy, resume, lrf_we and realloc_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sq_valid | input | 1 | Squash request |
| sq_oldest | input | $clog2(ROB_DEPTH) | Oldest squashed ROB index |
| sq_youngest | input | $clog2(ROB_DEPTH) | Youngest squashed ROB index |
| rob_head | input | $clog2(ROB_DEPTH) | ROB head, the age origin |
| rob_rd_idx | output | $clog2(ROB_DEPTH) | ROB entry being visited |
| rob_rel | input | 1 | Early-release flag of the visited entry |
| rob_inum | input | INUM_W | Writer instruction number of the visited entry |
| rob_lreg | input | $clog2(LOG_REGS) | Logical register of the released value |
| rob_preg | input | $clog2(PHYS_REGS) | Physical register to restore |
| rob_vq_slot | input | $clog2(VQ_DEPTH) | Value queue slot holding the old value |
| trl_done_inum | input | INUM_W | Number of the last instruction committed by the trailer |
| vq_raddr | output | $clog2(VQ_DEPTH) | Value queue read address |
| vq_rdata | input | DATA_W | Value queue read data |
| trl_raddr | output | $clog2(LOG_REGS) | Trailer register file read address (logical) |
| trl_rdata | input | DATA_W | Trailer register file read data |
| lrf_we | output | 1 | Leading register file write enable |
| lrf_waddr | output | $clog2(PHYS_REGS) | Leading register file write address |
| lrf_wdata | output | DATA_W | Leading register file write data |
| realloc_valid | output | 1 | Remove a register from the free pool |
| realloc_preg | output | $clog2(PHYS_REGS) | Register to remove |
| busy | output | 1 | Copy-back in progress |
| resume | output | 1 | Leading thread may restart |

## Verification
The bench covers the following corner cases, and each would show up differently if the design got it wrong:
- Squash ranges that wrap past the end of the ROB. A design that compared raw indices would walk the wrong entries.
- Writer numbers on both sides of the counter wrap, and exactly equal to the trailer count. A plain unsigned comparison, or an off-by-one, would take the value from the wrong source.
- Two flagged entries that restore the same register. Walking oldest to youngest would leave the younger value in place.
- A second squash in the middle of a walk, during the drain wait, and in the resume cycle. A design that dropped the request would resume too early, or leave registers unrestored. A design that did not restart from the younger bound would skip entries.

// File: rtl/er_pkg.sv
package er_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } er_state_e;
endpackage

// File: rtl/er_age_cmp.sv
// Circular age comparison: ages are measured forward from the ROB head.
module er_age_cmp #(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] head,
    input  logic [IDX_W-1:0] a,
    input  logic [IDX_W-1:0] b,
    output logic             a_younger
);
    logic [IDX_W-1:0] age_a;
    logic [IDX_W-1:0] age_b;

    assign age_a     = a - head;
    assign age_b     = b - head;
    assign a_younger = age_a > age_b;
endmodule

// File: rtl/er_src_sel.sv
// Picks the restore source: trailer file once the trailer has passed the writer.
module er_src_sel #(
    parameter int INUM_W = 16,
    parameter int DATA_W = 32
) (
    input  logic [INUM_W-1:0] wr_inum,
    input  logic [INUM_W-1:0] trl_done,
    input  logic [DATA_W-1:0] vq_data,
    input  logic [DATA_W-1:0] trl_data,
    output logic              from_trl,
    output logic [DATA_W-1:0] data
);
    logic [INUM_W-1:0] diff;

    assign diff     = trl_done - wr_inum;
    assign from_trl = ~diff[INUM_W-1];
    assign data     = from_trl ? trl_data : vq_data;
endmodule

// File: rtl/er_lat_timer.sv
// Counts the extra recovery penalty while run is held.
module er_lat_timer #(
    parameter int LAT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] LAST = CW'((LAT > 0) ? LAT - 1 : 0);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
        else          cnt_q <= '0;
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/eager_restore_ctrl.sv
module eager_restore_ctrl
    import er_pkg::*;
#(
    parameter int ROB_DEPTH = 16,   // power of two
    parameter int PHYS_REGS = 64,
    parameter int LOG_REGS  = 32,
    parameter int VQ_DEPTH  = 64,
    parameter int DATA_W    = 32,
    parameter int INUM_W    = 16,
    parameter int EXTRA_LAT = 5,
    localparam int RI_W = $clog2(ROB_DEPTH),
    localparam int PR_W = $clog2(PHYS_REGS),
    localparam int LR_W = $clog2(LOG_REGS),
    localparam int VQ_W = $clog2(VQ_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sq_valid,
    input  logic [RI_W-1:0]   sq_oldest,
    input  logic [RI_W-1:0]   sq_youngest,
    input  logic [RI_W-1:0]   rob_head,
    output logic [RI_W-1:0]   rob_rd_idx,
    input  logic              rob_rel,
    input  logic [INUM_W-1:0] rob_inum,
    input  logic [LR_W-1:0]   rob_lreg,
    input  logic [PR_W-1:0]   rob_preg,
    input  logic [VQ_W-1:0]   rob_vq_slot,
    input  logic [INUM_W-1:0] trl_done_inum,
    output logic [VQ_W-1:0]   vq_raddr,
    input  logic [DATA_W-1:0] vq_rdata,
    output logic [LR_W-1:0]   trl_raddr,
    input  logic [DATA_W-1:0] trl_rdata,
    output logic              lrf_we,
    output logic [PR_W-1:0]   lrf_waddr,
    output logic [DATA_W-1:0] lrf_wdata,
    output logic              realloc_valid,
    output logic [PR_W-1:0]   realloc_preg,
    output logic              busy,
    output logic              resume
);
    localparam bit HAS_DRAIN = (EXTRA_LAT > 0);

    er_state_e       state_q, state_d;
    logic [RI_W-1:0] cur_q, cur_d;
    logic [RI_W-1:0] stop_q, stop_d;
    logic [RI_W-1:0] head_q, head_d;

    logic            young_wins;    // new youngest is younger than the cursor
    logic            old_wins;      // old stop is younger than the new oldest
    logic            drain_expired;
    logic            from_trl;
    logic [DATA_W-1:0] sel_data;

    er_age_cmp #(.IDX_W(RI_W)) u_young (
        .head(head_q), .a(sq_youngest), .b(cur_q), .a_younger(young_wins)
    );

    er_age_cmp #(.IDX_W(RI_W)) u_old (
        .head(head_q), .a(stop_q), .b(sq_oldest), .a_younger(old_wins)
    );

    er_src_sel #(.INUM_W(INUM_W), .DATA_W(DATA_W)) u_src (
        .wr_inum(rob_inum), .trl_done(trl_done_inum),
        .vq_data(vq_rdata), .trl_data(trl_rdata),
        .from_trl(from_trl), .data(sel_data)
    );

    er_lat_timer #(.LAT(EXTRA_LAT)) u_lat (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_DRAIN),
        .expired(drain_expired)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            stop_q  <= '0;
            head_q  <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            stop_q  <= stop_d;
            head_q  <= head_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        stop_d  = stop_q;
        head_d  = head_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (sq_valid) begin
                    state_d = ST_WALK;
                    cur_d   = sq_youngest;
                    stop_d  = sq_oldest;
                    head_d  = rob_head;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WALK: begin
                if (sq_valid) begin
                    cur_d  = young_wins ? sq_youngest : cur_q;
                    stop_d = old_wins ? sq_oldest : stop_q;
                end else if (cur_q == stop_q) begin
                    state_d = HAS_DRAIN ? ST_DRAIN : ST_DONE;
                end else begin
                    cur_d = RI_W'(cur_q - 1'b1);
                end
            end
            ST_DRAIN: begin
                if (sq_valid) begin
                    state_d = ST_WALK;
                    cur_d   = sq_youngest;
                    stop_d  = old_wins ? sq_oldest : stop_q;
                end else if (drain_expired) begin
                    state_d = ST_DONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rob_rd_idx    = cur_q;
        vq_raddr      = rob_vq_slot;
        trl_raddr     = rob_lreg;
        lrf_we        = (state_q == ST_WALK) && rob_rel;
        lrf_waddr     = rob_preg;
        lrf_wdata     = sel_data;
        realloc_valid = (state_q == ST_WALK) && rob_rel;
        realloc_preg  = rob_preg;
        busy          = (state_q == ST_WALK) || (state_q == ST_DRAIN);
        resume        = (state_q == ST_DONE);
    end
endmodule

// File: rtl/er_restore_chk.sv
module er_restore_chk #(
    parameter int PHYS_REGS = 64,
    parameter int DATA_W    = 32,
    parameter int INUM_W    = 16,
    localparam int PR_W = $clog2(PHYS_REGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sq_valid,
    input logic              busy,
    input logic              resume,
    input logic              lrf_we,
    input logic [PR_W-1:0]   lrf_waddr,
    input logic [DATA_W-1:0] lrf_wdata,
    input logic              realloc_valid,
    input logic [PR_W-1:0]   realloc_preg,
    input logic [INUM_W-1:0] rob_inum,
    input logic [INUM_W-1:0] trl_done_inum,
    input logic [DATA_W-1:0] vq_rdata,
    input logic [DATA_W-1:0] trl_rdata
);
    logic [INUM_W-1:0] gap;
    assign gap = trl_done_inum - rob_inum;

    p_walk_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sq_valid) |=> busy);

    p_write_in_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lrf_we |-> busy);

    p_src_queue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lrf_we && gap[INUM_W-1]) |-> (lrf_wdata == vq_rdata));

    p_src_trailer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lrf_we && !gap[INUM_W-1]) |-> (lrf_wdata == trl_rdata));

    p_realloc_pairs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lrf_we |-> (realloc_valid && realloc_preg == lrf_waddr));

    p_resume_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> $past(busy));

    p_resume_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !resume);

    p_resume_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> !busy);

    p_merge_keeps_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sq_valid) |=> (busy && !resume));
endmodule

bind eager_restore_ctrl er_restore_chk #(
    .PHYS_REGS(PHYS_REGS), .DATA_W(DATA_W), .INUM_W(INUM_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sq_valid(sq_valid), .busy(busy),
    .resume(resume), .lrf_we(lrf_we), .lrf_waddr(lrf_waddr),
    .lrf_wdata(lrf_wdata), .realloc_valid(realloc_valid),
    .realloc_preg(realloc_preg), .rob_inum(rob_inum),
    .trl_done_inum(trl_done_inum), .vq_rdata(vq_rdata), .trl_rdata(trl_rdata)
);

// File: tb/sim_eager_restore_ctrl.sv
`timescale 1ns/1ps
module sim_eager_restore_ctrl;
    localparam int ROBD = 16;
    localparam int NPR  = 64;
    localparam int NLR  = 32;
    localparam int NVQ  = 64;
    localparam int LAT  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sq_valid = 1'b0;
    logic [3:0]  sq_oldest = '0, sq_youngest = '0, rob_head = '0;
    logic [3:0]  rob_rd_idx;
    logic        rob_rel;
    logic [15:0] rob_inum;
    logic [4:0]  rob_lreg;
    logic [5:0]  rob_preg;
    logic [5:0]  rob_vq_slot;
    logic [15:0] trl_done_inum = '0;
    logic [5:0]  vq_raddr;
    logic [31:0] vq_rdata;
    logic [4:0]  trl_raddr;
    logic [31:0] trl_rdata;
    logic        lrf_we;
    logic [5:0]  lrf_waddr;
    logic [31:0] lrf_wdata;
    logic        realloc_valid;
    logic [5:0]  realloc_preg;
    logic        busy, resume;

    always #4 clk = ~clk;   // 125 MHz

    // Side tables the controller reads
    logic        m_rel  [ROBD];
    logic [15:0] m_inum [ROBD];
    logic [4:0]  m_lreg [ROBD];
    logic [5:0]  m_preg [ROBD];
    logic [5:0]  m_slot [ROBD];
    logic [31:0] m_vq   [NVQ];
    logic [31:0] m_trf  [NLR];

    assign rob_rel     = m_rel[rob_rd_idx];
    assign rob_inum    = m_inum[rob_rd_idx];
    assign rob_lreg    = m_lreg[rob_rd_idx];
    assign rob_preg    = m_preg[rob_rd_idx];
    assign rob_vq_slot = m_slot[rob_rd_idx];
    assign vq_rdata    = m_vq[vq_raddr];
    assign trl_rdata   = m_trf[trl_raddr];

    eager_restore_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sq_valid(sq_valid), .sq_oldest(sq_oldest),
        .sq_youngest(sq_youngest), .rob_head(rob_head), .rob_rd_idx(rob_rd_idx),
        .rob_rel(rob_rel), .rob_inum(rob_inum), .rob_lreg(rob_lreg),
        .rob_preg(rob_preg), .rob_vq_slot(rob_vq_slot),
        .trl_done_inum(trl_done_inum), .vq_raddr(vq_raddr), .vq_rdata(vq_rdata),
        .trl_raddr(trl_raddr), .trl_rdata(trl_rdata), .lrf_we(lrf_we),
        .lrf_waddr(lrf_waddr), .lrf_wdata(lrf_wdata),
        .realloc_valid(realloc_valid), .realloc_preg(realloc_preg),
        .busy(busy), .resume(resume)
    );

    typedef struct {
        int          ph;     // -1 idle, 0 walk, 1 drain, 2 done
        int          idx;
        bit          we;
        int          preg;
        logic [31:0] data;
        string       dtag;   // R3 or R4
        string       wtag;   // R1, R9 or R10
    } exp_t;

    exp_t        exp_q[$];
    int          n_chk = 0, n_err = 0;
    int          lastph = -1, lastidx = 0;
    int          head_m = 0, stop_m = 0;
    logic [31:0] img_dut [NPR];
    logic [31:0] img_exp [NPR];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int age(input int x, input int h);
        return (x - h + ROBD) % ROBD;
    endfunction

    // Restore value chosen from the requirements: trailer once it has passed the writer
    function automatic logic [31:0] want_data(input int i, output string tag);
        logic [15:0] d;
        d = trl_done_inum - m_inum[i];
        if (d[15]) begin tag = "R3"; return m_vq[m_slot[i]]; end
        tag = "R4";
        return m_trf[m_lreg[i]];
    endfunction

    task automatic build(input int cur, input int stp, input string wtag);
        exp_t it;
        exp_q.delete();
        stop_m = stp;
        for (int a = age(cur, head_m); a >= age(stp, head_m); a--) begin
            it.ph   = 0;
            it.idx  = (head_m + a) % ROBD;
            it.we   = m_rel[it.idx];
            it.preg = int'(m_preg[it.idx]);
            it.data = want_data(it.idx, it.dtag);
            it.wtag = wtag;
            exp_q.push_back(it);
        end
        for (int k = 0; k < LAT; k++) begin
            it.ph = 1; it.we = 0;
            exp_q.push_back(it);
        end
        it.ph = 2; it.we = 0;
        exp_q.push_back(it);
    endtask

    task automatic step();
        exp_t it;
        if (exp_q.size() > 0) it = exp_q.pop_front();
        else begin
            it.ph = -1; it.idx = 0; it.we = 0; it.preg = 0; it.data = '0;
            it.dtag = "R3"; it.wtag = "R1";
        end
        chk(busy == (it.ph == 0 || it.ph == 1), "R6 busy", busy,
            (it.ph == 0 || it.ph == 1));
        chk(resume == (it.ph == 2), "R7 resume", resume, (it.ph == 2));
        chk(lrf_we == it.we, "R2 write enable", lrf_we, it.we);
        chk(realloc_valid == it.we, "R5 realloc valid", realloc_valid, it.we);
        if (it.ph == 0) begin
            chk(int'(rob_rd_idx) == it.idx, {it.wtag, " walk index"}, rob_rd_idx, it.idx);
            if (it.we) begin
                chk(int'(lrf_waddr) == it.preg, "R2 write address", lrf_waddr, it.preg);
                chk(lrf_wdata == it.data, {it.dtag, " restore data"}, lrf_wdata, it.data);
                chk(int'(realloc_preg) == it.preg, "R5 realloc reg", realloc_preg, it.preg);
            end
        end
        if (lrf_we) img_dut[lrf_waddr] = lrf_wdata;
        if (it.we)  img_exp[it.preg]  = it.data;
        lastph  = it.ph;
        lastidx = it.idx;
    endtask

    task automatic tick();
        @(negedge clk);
        step();
    endtask

    // Issue a squash right after the current cycle's comparison
    task automatic squash(input int old, input int young);
        sq_valid    = 1'b1;
        sq_oldest   = 4'(old);
        sq_youngest = 4'(young);
        if (lastph == -1 || lastph == 2) begin
            head_m = int'(rob_head);
            build(young, old, (lastph == 2) ? "R10" : "R1");
        end else begin
            int nc, ns;
            ns = (age(stop_m, head_m) > age(old, head_m)) ? old : stop_m;
            if (lastph == 0)
                nc = (age(young, head_m) > age(lastidx, head_m)) ? young : lastidx;
            else
                nc = young;
            build(nc, ns, "R9");
        end
        tick();
        sq_valid = 1'b0;
    endtask

    task automatic run_out();
        while (exp_q.size() > 0) tick();
        tick();
    endtask

    task automatic clear_rob();
        for (int i = 0; i < ROBD; i++) begin
            m_rel[i] = 0; m_inum[i] = '0; m_lreg[i] = '0; m_preg[i] = '0; m_slot[i] = '0;
        end
    endtask

    task automatic set_ent(input int i, input bit rel, input int inum, input int lreg,
                           input int preg, input int slot);
        m_rel[i] = rel; m_inum[i] = 16'(inum); m_lreg[i] = 5'(lreg);
        m_preg[i] = 6'(preg); m_slot[i] = 6'(slot);
    endtask

    task automatic image_check(input string req);
        bit same;
        same = 1;
        for (int i = 0; i < NPR; i++) if (img_dut[i] !== img_exp[i]) same = 0;
        chk(same, {req, " final register image"}, 32'(same), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL R6 watchdog actual=hung expected=resume");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < NVQ; i++) m_vq[i] = 32'hA000_0000 + 32'(i);
        for (int i = 0; i < NLR; i++) m_trf[i] = 32'hB000_0000 + 32'(i);
        for (int i = 0; i < NPR; i++) begin img_dut[i] = '0; img_exp[i] = '0; end
        clear_rob();

        // R11: outputs quiet in reset
        repeat (2) begin
            @(negedge clk);
            chk(!busy && !resume, "R11 busy/resume in reset", {busy, resume}, 0);
            chk(!lrf_we && !realloc_valid, "R11 write in reset", {lrf_we, realloc_valid}, 0);
        end
        rst_n = 1'b1;
        tick();

        // T1: mixed sources, equal numbers go to the trailer (R1-related walk, R3, R4)
        trl_done_inum = 16'd100;
        rob_head = 4'd0;
        set_ent(2, 1, 90, 3, 10, 5);
        set_ent(4, 1, 100, 4, 11, 6);
        set_ent(5, 1, 105, 5, 12, 7);
        set_ent(6, 1, 101, 6, 13, 8);
        squash(2, 6);
        run_out();
        image_check("R2");

        // T2: index range and writer numbers both wrap
        clear_rob();
        trl_done_inum = 16'h0003;
        rob_head = 4'd12;
        set_ent(14, 1, 16'hFFFE, 9, 20, 30);
        set_ent(0, 1, 16'h0005, 10, 21, 31);
        set_ent(1, 1, 16'h0003, 11, 22, 32);
        set_ent(3, 1, 16'h8002, 12, 23, 33);
        squash(14, 3);
        run_out();
        image_check("R4");

        // T3: same register restored twice, oldest value stays (R8)
        clear_rob();
        trl_done_inum = 16'd0;
        rob_head = 4'd0;
        set_ent(1, 1, 10, 1, 7, 10);
        set_ent(3, 1, 20, 2, 7, 20);
        set_ent(4, 1, 30, 3, 8, 21);
        squash(1, 4);
        run_out();
        chk(img_dut[7] == m_vq[10], "R8 oldest restore wins", img_dut[7], m_vq[10]);
        image_check("R8");

        // T4: squash merges during the walk (R9)
        clear_rob();
        trl_done_inum = 16'd50;
        for (int i = 3; i <= 11; i++) set_ent(i, (i % 2) == 1, 40 + i, i, 30 + i, i);
        squash(5, 9);
        tick();
        tick();
        squash(3, 11);
        run_out();
        image_check("R9");

        // T5: squash merges during the drain wait (R9)
        squash(5, 6);
        while (lastph != 1) tick();
        tick();
        squash(4, 8);
        run_out();
        image_check("R9");

        // T6: squash in the resume cycle starts afresh with a new head (R10)
        squash(7, 7);
        while (lastph != 2) tick();
        rob_head = 4'd2;
        squash(8, 9);
        run_out();
        image_check("R10");

        // T7: nothing flagged: no writes, still full latency before resume (R2, R6)
        clear_rob();
        rob_head = 4'd0;
        squash(0, 3);
        run_out();
        image_check("R2");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule